// File: doc/BRIEF.md
# Bidirectional GPIO Port with Upper-Nibble Change Detection

This block is an 8-bit general-purpose I/O port. Each pin has a direction bit and an output data bit. The pad-side input is brought through a two-stage synchronizer before the CPU reads it or the change detector looks at it. The pad side receives three per-pin values: the output value, an output-enable and a weak pull-up enable. The CPU uses a small register window to read and write the data latch, the direction register and a control register. The control register holds an active-low pull-up disable bit and a change flag that the CPU can read and clear.

Each of the upper four pins, while set as an input, is compared against a snapshot taken at the most recent CPU access to the data register. Any difference raises a wake request and sets the change flag. Accessing the data register again takes a new snapshot, and that ends the mismatch. Clearing the flag while a difference is still present does not clear it, because the flag is set again.

Top module: `gpio_ioc_port`

## Requirements
- R1: After reset, every direction bit is 1, so `pad_oe_o` is 0x00. The output latch is 0x00, `pad_pu_o` is 0x00, `irq_o` is 0, and reading the control register (address 2) returns 0x01.
- R2: The direction register sits at address 1, and a 0 bit makes that pin an output. One cycle after a write, `pad_oe_o` equals the inverse of the written value, and reading address 1 returns the written value.
- R3: A write to address 0 loads the output latch, which appears on `pad_o` on the next cycle. A read of address 0 returns the pad values after they pass two synchronizer flops.
- R4: The control register holds the pull-up disable bit at bit 0, active low. While that bit is 0, `pad_pu_o` is 1 exactly on the pins whose direction bit is 1. While it is 1, `pad_pu_o` is all zero.
- R5: Only pins 7:4 take part in change detection, and only while their direction bit is 1. Changes on pins 3:0, or on upper pins set as outputs, leave `wake_o` and `irq_o` at 0.
- R6: When a participating synchronized input differs from its snapshot, `wake_o` is 1 and the flag (`irq_o`, control register bit 1) is set one cycle later.
- R7: A read or a write of address 0 replaces the snapshot with the current synchronized inputs. This drops `wake_o` on the next cycle, and the flag stays set.
- R8: Writing the control register with bit 1 equal to 0 clears the flag, unless a mismatch is present in that cycle. In that case the flag stays set.
- R9: Writing the control register with bit 1 equal to 1 never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 data, 1 direction, 2 control |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a data read takes the snapshot) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| pad_i | input | 8 | Pin levels from the pads |
| pad_o | output | 8 | Output latch value to the pads |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_pu_o | output | 8 | Per-pin weak pull-up enable |
| irq_o | output | 1 | Change flag |
| wake_o | output | 1 | Wake request, high while a mismatch is present |

## Verification
The change detector is tested with four kinds of pin activity:
- A flip on an upper input pin, which must raise both the wake request and the flag.
- A flip on the lower nibble, which must be ignored.
- A flip on an upper pin that is set as an output, which must also be ignored.
- Pad changes made while the upper pins are outputs and the lower pins are inputs, which must show up on a data read but raise nothing.

Ending the mismatch is tried both with a data read and with a data write. These two cases show that the snapshot follows port accesses in general, not reads alone. A flag clear is issued both while the mismatch persists and after it ends, which separates clear-over-set from set-over-clear priority.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_PU_BIT   = 0;
  localparam int unsigned CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_we_i,
  input  logic         dir_we_i,
  input  logic         pu_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pu_dis_n_i,
  output logic [W-1:0] dir_o,
  output logic         pu_dis_n_o,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_pu_o
);
  logic [W-1:0] lat_q, dir_q;
  logic         pu_dis_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q      <= '0;
      dir_q      <= '1;
      pu_dis_n_q <= 1'b1;
    end else begin
      if (data_we_i) lat_q <= wdata_i;
      if (dir_we_i)  dir_q <= wdata_i;
      if (pu_we_i)   pu_dis_n_q <= pu_dis_n_i;
    end
  end

  assign dir_o      = dir_q;
  assign pu_dis_n_o = pu_dis_n_q;
  assign pad_o      = lat_q;
  assign pad_oe_o   = ~dir_q;
  // pull-up only on inputs, and only while globally enabled
  assign pad_pu_o   = dir_q & {W{~pu_dis_n_q}};

  p_pu_inputs_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);
  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> pad_oe_o == ~$past(wdata_i));
endmodule

// File: rtl/gpio_ioc.sv
module gpio_ioc #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] dir_i,
  input  logic         port_acc_i,
  input  logic         flag_clr_i,
  output logic         mismatch_o,
  output logic         flag_o
);
  logic [W-1:0] snap_q;
  logic [W-1:0] diff;
  logic         flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (port_acc_i) snap_q <= pin_i;
  end

  assign diff       = (pin_i ^ snap_q) & dir_i;
  assign mismatch_o = |diff;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (mismatch_o) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  p_set_on_mismatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> flag_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !mismatch_o) |=> !flag_o);
  p_outputs_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == '0) |-> !mismatch_o);
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned IOC_LO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pad_pu_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int unsigned IOC_W = WIDTH - IOC_LO;

  reg_sel_e         sel;
  logic [WIDTH-1:0] pin_sync, dir;
  logic             pu_dis_n, flag, mismatch;
  logic             data_we, dir_we, ctrl_we, port_acc, flag_clr;

  assign sel      = reg_sel_e'(addr_i);
  assign data_we  = wr_en_i && sel == SEL_DATA;
  assign dir_we   = wr_en_i && sel == SEL_DIR;
  assign ctrl_we  = wr_en_i && sel == SEL_CTRL;
  assign port_acc = (wr_en_i || rd_en_i) && sel == SEL_DATA;
  assign flag_clr = ctrl_we && !wdata_i[CTRL_FLAG_BIT];

  gpio_sync #(.W(WIDTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pin_sync)
  );

  gpio_pin_ctrl #(.W(WIDTH)) u_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_we_i (data_we),
    .dir_we_i  (dir_we),
    .pu_we_i   (ctrl_we),
    .wdata_i   (wdata_i),
    .pu_dis_n_i(wdata_i[CTRL_PU_BIT]),
    .dir_o     (dir),
    .pu_dis_n_o(pu_dis_n),
    .pad_o     (pad_o),
    .pad_oe_o  (pad_oe_o),
    .pad_pu_o  (pad_pu_o)
  );

  gpio_ioc #(.W(IOC_W)) u_ioc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_sync[WIDTH-1:IOC_LO]),
    .dir_i     (dir[WIDTH-1:IOC_LO]),
    .port_acc_i(port_acc),
    .flag_clr_i(flag_clr),
    .mismatch_o(mismatch),
    .flag_o    (flag)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_DATA: rdata_o = pin_sync;
      SEL_DIR:  rdata_o = dir;
      SEL_CTRL: begin
        rdata_o[CTRL_PU_BIT]   = pu_dis_n;
        rdata_o[CTRL_FLAG_BIT] = flag;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o  = flag;
  assign wake_o = mismatch;

  p_flag_not_set_by_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !irq_o && !wake_o) |=> !irq_o);
  p_access_keeps_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_acc && irq_o) |=> irq_o);
endmodule

// File: tb/gpio_ioc_port_test.sv
`timescale 1ns/1ps
module gpio_ioc_port_test;
  typedef enum int {K_RDATA, K_PAD, K_OE, K_PU, K_IRQ, K_WAKE} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 0, rst_ni = 0;
  logic [1:0] addr_i = 0;
  logic       wr_en_i = 0, rd_en_i = 0;
  logic [7:0] wdata_i = 0, pad_i = 0;
  logic [7:0] rdata_o, pad_o, pad_oe_o, pad_pu_o;
  logic       irq_o, wake_o;

  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_ioc_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  // monitor: pops expectations 2 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RDATA: act = rdata_o;
        K_PAD:   act = pad_o;
        K_OE:    act = pad_oe_o;
        K_PU:    act = pad_pu_o;
        K_IRQ:   act = {7'd0, irq_o};
        default: act = {7'd0, wake_o};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %02h expected %02h", it.req, it.kind.name(), act, it.exp);
      end
    end
  end

  task automatic chk(kind_e k, logic [7:0] e, string r);
    @(negedge clk);
    sb.push_back('{k, e, r});
  endtask

  task automatic cpu_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1;
    @(posedge clk); #1;
    wr_en_i = 0;
  endtask

  task automatic cpu_rd(logic [1:0] a, logic [7:0] e, string r);
    @(negedge clk);
    addr_i = a; rd_en_i = 1;
    sb.push_back('{K_RDATA, e, r});
    @(posedge clk); #1;
    rd_en_i = 0;
  endtask

  task automatic set_pad(logic [7:0] v);
    @(negedge clk);
    pad_i = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    @(negedge clk); #5;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    chk(K_OE, 8'h00, "R1"); chk(K_PAD, 8'h00, "R1");
    chk(K_PU, 8'h00, "R1"); chk(K_IRQ, 8'h00, "R1");
    cpu_rd(2'd2, 8'h01, "R1");
    // R2 direction, R3 output latch
    cpu_wr(2'd1, 8'h0F);
    chk(K_OE, 8'hF0, "R2");
    cpu_rd(2'd1, 8'h0F, "R2");
    cpu_wr(2'd0, 8'hA5);
    chk(K_PAD, 8'hA5, "R3");
    // R5 low nibble inputs + upper outputs change: ignored
    set_pad(8'h5A);
    chk(K_WAKE, 8'h00, "R5"); chk(K_IRQ, 8'h00, "R5");
    cpu_rd(2'd0, 8'h5A, "R3");
    // R4 pull-ups
    cpu_wr(2'd2, 8'h02);
    chk(K_PU, 8'h0F, "R4");
    cpu_wr(2'd1, 8'hFF);
    chk(K_PU, 8'hFF, "R4"); chk(K_OE, 8'h00, "R2");
    chk(K_IRQ, 8'h00, "R6");
    // R6 upper input change
    set_pad(8'h9A);
    chk(K_WAKE, 8'h01, "R6"); chk(K_IRQ, 8'h01, "R6");
    cpu_rd(2'd2, 8'h02, "R6");
    // R8 clear while mismatch present
    cpu_wr(2'd2, 8'h00);
    chk(K_IRQ, 8'h01, "R8"); chk(K_WAKE, 8'h01, "R8");
    // R7 read ends mismatch
    cpu_rd(2'd0, 8'h9A, "R3");
    chk(K_WAKE, 8'h00, "R7"); chk(K_IRQ, 8'h01, "R7");
    // R8 clear after mismatch gone
    cpu_wr(2'd2, 8'h00);
    chk(K_IRQ, 8'h00, "R8");
    // R9 writing flag bit 1 does not set
    cpu_wr(2'd2, 8'h02);
    chk(K_IRQ, 8'h00, "R9");
    // R5 low nibble input change ignored
    set_pad(8'h95);
    chk(K_WAKE, 8'h00, "R5"); chk(K_IRQ, 8'h00, "R5");
    // R7 write ends mismatch
    set_pad(8'h15);
    chk(K_WAKE, 8'h01, "R7");
    cpu_wr(2'd0, 8'h3C);
    chk(K_WAKE, 8'h00, "R7"); chk(K_IRQ, 8'h01, "R7");
    chk(K_PAD, 8'h3C, "R3");
    // R5 upper pin as output ignored
    cpu_wr(2'd2, 8'h00);
    chk(K_IRQ, 8'h00, "R8");
    cpu_wr(2'd1, 8'h7F);
    chk(K_OE, 8'h80, "R2"); chk(K_PU, 8'h7F, "R4");
    set_pad(8'h95);
    chk(K_WAKE, 8'h00, "R5"); chk(K_IRQ, 8'h00, "R5");
    // R4 disable pull-ups
    cpu_wr(2'd2, 8'h01);
    chk(K_PU, 8'h00, "R4");
    cpu_rd(2'd2, 8'h01, "R4");
    repeat (2) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule